// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block watches the stream of results coming out of an analog-to-digital converter and flags any result that lands outside a programmable window. Each result arrives with a valid strobe, its channel number and a tag that says whether it came from the regular sequence or from an inserted (priority) sequence. A result is checked only if monitoring is on for its group. When single-channel mode is selected, its channel must also match the configured channel.

The check uses the raw, unaligned result. The thresholds therefore mean the same thing whatever alignment or offset later stages apply. A result that falls below the low bound or above the high bound sets a sticky event flag. The flag holds until an explicit clear. An interrupt output follows the flag, gated by an interrupt enable. All configuration is applied as plain input ports.

Top module: `awd_window_watchdog`

## Requirements
- R1: After a synchronous reset, `evt_flag` and `irq` are both 0.
- R2: A valid regular-group result (`res_inserted`=0) that is outside the window, with `cfg_reg_en`=1, sets `evt_flag` at the first rising clock edge that samples the strobe.
- R3: The two groups are qualified independently. A valid result whose group has its enable at 0 (`cfg_reg_en` for `res_inserted`=0, `cfg_ins_en` for `res_inserted`=1) never sets `evt_flag`. A valid inserted-group result with `cfg_ins_en`=1 that is outside the window sets it.
- R4: A result strictly below `cfg_low` and a result strictly above `cfg_high` both count as outside the window. The values are 12-bit unsigned.
- R5: A result equal to `cfg_low` or equal to `cfg_high`, or lying between them, is inside the window and raises no event.
- R6: With `cfg_single`=1, only results whose `res_chan` equals `cfg_chan` are checked. Results from every other channel are ignored.
- R7: With `cfg_single`=0, results from any channel of an enabled group are checked.
- R8: `evt_flag` stays set until `evt_clear` is sampled high. At that edge it returns to 0, even if an out-of-window result is sampled at the same edge.
- R9: `irq` is registered. At each edge it takes the value (next `evt_flag` AND `cfg_irq_en`).
- R10: When `res_valid` is 0, `res_data`, `res_chan` and `res_inserted` have no effect on `evt_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe |
| res_data | input | 12 | Raw unaligned conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_inserted | input | 1 | Group tag: 0 regular, 1 inserted |
| cfg_reg_en | input | 1 | Monitor regular-group results |
| cfg_ins_en | input | 1 | Monitor inserted-group results |
| cfg_single | input | 1 | Restrict monitoring to `cfg_chan` |
| cfg_chan | input | 5 | Channel watched in single-channel mode |
| cfg_high | input | 12 | Upper window bound (inclusive inside) |
| cfg_low | input | 12 | Lower window bound (inclusive inside) |
| cfg_irq_en | input | 1 | Interrupt enable |
| evt_clear | input | 1 | Clears the sticky event flag |
| evt_flag | output | 1 | Sticky out-of-window event flag |
| irq | output | 1 | Gated interrupt |

## Verification
Both outputs are due exactly one edge after the inputs that cause them. The flag reacts at the edge that samples a result strobe or a clear. The interrupt reacts at the same edge to the flag and to `cfg_irq_en`. The bench drives all inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. The single cycle of latency is therefore checked directly, not only eventually. Each ignored-stimulus case is checked at the flag after that same single edge, before the flag is cleared for the next vector.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INSERTED = 1'b1
  } awd_group_e;
endpackage

// File: rtl/awd_select.sv
// Decides whether a result is subject to monitoring: group enable plus
// optional single-channel restriction.
module awd_select
  import awd_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              valid,
  input  awd_group_e        group,
  input  logic [CHAN_W-1:0] chan,
  input  logic              reg_en,
  input  logic              ins_en,
  input  logic              single,
  input  logic [CHAN_W-1:0] chan_sel,
  output logic              watch
);
  logic grp_on;
  logic chan_ok;

  always_comb begin
    grp_on  = (group == GRP_INSERTED) ? ins_en : reg_en;
    chan_ok = !single || (chan == chan_sel);
    watch   = valid && grp_on && chan_ok;
  end
endmodule

// File: rtl/awd_window.sv
// Unsigned window compare on the raw (unaligned) result.
module awd_window #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] high,
  input  logic [DATA_W-1:0] low,
  output logic              outside
);
  logic below;
  logic above;

  always_comb begin
    below   = data < low;
    above   = data > high;
    outside = below || above;
  end
endmodule

// File: rtl/awd_flag.sv
// Sticky event flag and registered interrupt.
module awd_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clear,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_d;

  always_comb begin
    if (clear) flag_d = 1'b0;
    else       flag_d = flag || hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= flag_d && irq_en;
    end
  end

  // R2: a qualified out-of-window hit without clear sets the flag next cycle
  assert_hit_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && !clear) |=> flag);

  // R8: clear wins and the flag is otherwise sticky
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clear) |=> flag);

  // R10: nothing sets the flag without a hit
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !flag);

  // R9: interrupt tracks flag gated by previous-cycle enable
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && $past(irq_en)));
endmodule

// File: rtl/awd_window_watchdog.sv
module awd_window_watchdog
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_inserted,
  input  logic              cfg_reg_en,
  input  logic              cfg_ins_en,
  input  logic              cfg_single,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [DATA_W-1:0] cfg_high,
  input  logic [DATA_W-1:0] cfg_low,
  input  logic              cfg_irq_en,
  input  logic              evt_clear,
  output logic              evt_flag,
  output logic              irq
);
  awd_group_e grp;
  logic       watch;
  logic       outside;
  logic       hit;

  assign grp = awd_group_e'(res_inserted);
  assign hit = watch && outside;

  awd_select #(.CHAN_W(CHAN_W)) u_select (
    .valid    (res_valid),
    .group    (grp),
    .chan     (res_chan),
    .reg_en   (cfg_reg_en),
    .ins_en   (cfg_ins_en),
    .single   (cfg_single),
    .chan_sel (cfg_chan),
    .watch    (watch)
  );

  awd_window #(.DATA_W(DATA_W)) u_window (
    .data    (res_data),
    .high    (cfg_high),
    .low     (cfg_low),
    .outside (outside)
  );

  awd_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .clear  (evt_clear),
    .irq_en (cfg_irq_en),
    .flag   (evt_flag),
    .irq    (irq)
  );

  // R3: a result from a disabled group leaves a clear flag clear
  assert_group_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!evt_flag && res_valid &&
     ((!res_inserted && !cfg_reg_en) || (res_inserted && !cfg_ins_en)))
    |=> !evt_flag);

  // R6: in single-channel mode other channels are ignored
  assert_single_chan_R6: assert property (@(posedge clk) disable iff (rst)
    (!evt_flag && cfg_single && res_chan != cfg_chan) |=> !evt_flag);

  // R5: an in-window result never raises the flag
  assert_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    (!evt_flag && res_data >= cfg_low && res_data <= cfg_high) |=> !evt_flag);
endmodule

// File: tb/awd_window_watchdog_tb_top.sv
module awd_window_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        res_valid;
  logic [11:0] res_data;
  logic [4:0]  res_chan;
  logic        res_inserted;
  logic        cfg_reg_en, cfg_ins_en, cfg_single;
  logic [4:0]  cfg_chan;
  logic [11:0] cfg_high, cfg_low;
  logic        cfg_irq_en;
  logic        evt_clear;
  logic        evt_flag, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk; // 250 MHz

  awd_window_watchdog dut_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_inserted(res_inserted),
    .cfg_reg_en(cfg_reg_en), .cfg_ins_en(cfg_ins_en), .cfg_single(cfg_single),
    .cfg_chan(cfg_chan), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_irq_en(cfg_irq_en), .evt_clear(evt_clear),
    .evt_flag(evt_flag), .irq(irq)
  );

  typedef struct packed {
    logic       ren;
    logic       ien;
    logic       single;
    logic [4:0] sel;
    logic [11:0] hi;
    logic [11:0] lo;
    logic       ins;
    logic [4:0] chan;
    logic [11:0] data;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd3500, 1'b1, 4'd2},  // R2 above
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd999,  1'b1, 4'd4},  // R4 below
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd3001, 1'b1, 4'd4},  // R4 just above
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd1000, 1'b0, 4'd5},  // R5 = low
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd3000, 1'b0, 4'd5},  // R5 = high
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd2000, 1'b0, 4'd5},  // R5 inside
    '{1'b1,1'b0,1'b0,5'd0, 12'd4095,12'd0,    1'b0,5'd3, 12'd4095, 1'b0, 4'd5},  // R5 full range
    '{1'b0,1'b1,1'b0,5'd0, 12'd3000,12'd1000, 1'b0,5'd3, 12'd3500, 1'b0, 4'd3},  // R3 regular off
    '{1'b1,1'b0,1'b0,5'd0, 12'd3000,12'd1000, 1'b1,5'd3, 12'd3500, 1'b0, 4'd3},  // R3 inserted off
    '{1'b0,1'b1,1'b0,5'd0, 12'd3000,12'd1000, 1'b1,5'd3, 12'd10,   1'b1, 4'd3},  // R3 inserted on
    '{1'b1,1'b1,1'b1,5'd7, 12'd3000,12'd1000, 1'b0,5'd7, 12'd3500, 1'b1, 4'd6},  // R6 match
    '{1'b1,1'b1,1'b1,5'd7, 12'd3000,12'd1000, 1'b0,5'd6, 12'd3500, 1'b0, 4'd6},  // R6 other chan
    '{1'b1,1'b1,1'b1,5'd7, 12'd3000,12'd1000, 1'b1,5'd31,12'd5,    1'b0, 4'd6},  // R6 other chan ins
    '{1'b1,1'b1,1'b0,5'd7, 12'd3000,12'd1000, 1'b0,5'd31,12'd3500, 1'b1, 4'd7},  // R7 any chan
    '{1'b1,1'b1,1'b0,5'd7, 12'd3000,12'd1000, 1'b1,5'd0, 12'd0,    1'b1, 4'd7},  // R7 any chan ins
    '{1'b1,1'b1,1'b0,5'd7, 12'd100, 12'd50,   1'b1,5'd9, 12'd2048, 1'b1, 4'd4}   // R4 narrow window
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    evt_clear = 1'b1;
    tick();
    evt_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; res_valid = 1'b0; res_data = '0; res_chan = '0; res_inserted = 1'b0;
    cfg_reg_en = 1'b1; cfg_ins_en = 1'b1; cfg_single = 1'b0; cfg_chan = '0;
    cfg_high = 12'd3000; cfg_low = 12'd1000; cfg_irq_en = 1'b1; evt_clear = 1'b0;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    check(evt_flag, 1'b0, "R1 flag");
    check(irq, 1'b0, "R1 irq");
    rst = 1'b0;
    cfg_irq_en = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      cfg_reg_en = TBL[i].ren; cfg_ins_en = TBL[i].ien; cfg_single = TBL[i].single;
      cfg_chan = TBL[i].sel; cfg_high = TBL[i].hi; cfg_low = TBL[i].lo;
      res_inserted = TBL[i].ins; res_chan = TBL[i].chan; res_data = TBL[i].data;
      res_valid = 1'b1;
      tick();
      res_valid = 1'b0;
      check(evt_flag, TBL[i].exp, $sformatf("R%0d vec %0d", TBL[i].req, i));
      clear_flag();
    end

    cfg_reg_en = 1'b1; cfg_ins_en = 1'b1; cfg_single = 1'b0;
    cfg_high = 12'd3000; cfg_low = 12'd1000;

    // R10: bad data with valid low is ignored
    res_valid = 1'b0; res_data = 12'd4000;
    tick(); tick();
    check(evt_flag, 1'b0, "R10 no strobe");

    // R8: sticky across in-window results and idle cycles
    res_valid = 1'b1; res_data = 12'd4000; tick();
    res_data = 12'd2000; tick(); tick();
    res_valid = 1'b0; tick();
    check(evt_flag, 1'b1, "R8 sticky");

    // R8: clear wins over a coincident event
    res_valid = 1'b1; res_data = 12'd4000; evt_clear = 1'b1;
    tick();
    res_valid = 1'b0; evt_clear = 1'b0;
    check(evt_flag, 1'b0, "R8 clear wins");

    // R9: interrupt gating
    cfg_irq_en = 1'b0;
    res_valid = 1'b1; res_data = 12'd5; tick();
    res_valid = 1'b0;
    check(irq, 1'b0, "R9 irq masked");
    cfg_irq_en = 1'b1; tick();
    check(irq, 1'b1, "R9 irq enabled");
    cfg_irq_en = 1'b0; tick();
    check(irq, 1'b0, "R9 irq dropped");
    check(evt_flag, 1'b1, "R9 flag kept");
    cfg_irq_en = 1'b1; tick();
    clear_flag();
    check(irq, 1'b0, "R9 irq after clear");

    // R2: event and interrupt in the same edge
    res_valid = 1'b1; res_data = 12'd3900; tick();
    res_valid = 1'b0;
    check(irq, 1'b1, "R2 irq with event");

    done = 1;
    finish_run();
  end
endmodule